// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator

This block gathers a wide bundle of peripheral interrupt request lines and folds them onto a small set of core event inputs. Each source carries an enable (mask) bit, a live status bit visible to software, a wake-enable bit, and a 4-bit field that names the event input it feeds. When several unmasked sources point at the same event input, their requests are ORed together.

Each event input has a rising-edge detector and a pending latch, and the latch drives the core. The detector needs two clock edges to recognise an edge. The pending bit stays set until the core raises its in-service indication for that event. From then on, a fresh rising edge on the same input is latched as a new event, even while in-service is still high.

A separate wake request is formed from every source whose wake-enable bit is set. It is gated by the core's sleep indication and registered once before it leaves the block. All configuration is reached through a single-cycle register port with combinational read data.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every register word reads zero, all pending outputs are low and the wake output is low.
- R2: Word addresses 0 to 2 hold the enable bits. Bit b of word w belongs to source 32*w+b. A 1 lets the source drive its event input. A 0 stops that source from having any effect on the pending outputs.
- R3: Word addresses 3 to 5 read the live request level of sources 32*(a-3) to 32*(a-3)+31, whatever the enable bits hold. Writes to these addresses have no effect.
- R4: Word addresses 6 to 8 hold the wake-enable bits, using the same bit layout as R2. The wake output after clock edge k equals the core sleep input at edge k ANDed with the OR of (request AND wake-enable) over all sources at edge k.
- R5: Word addresses 9 to 20 hold the routing fields. Source s is routed by word 9+s/8, bits [4*(s%8)+3 : 4*(s%8)]. Each event input is the OR of all enabled requests routed to it.
- R6: If an event input is low at clock edge k-1 and high at edge k, its pending output is high after edge k+1. An input that is held high does not set the pending bit again.
- R7: If the in-service input of an event is low at edge k-1 and high at edge k, that event's pending output is low after edge k, unless R8 applies.
- R8: A rising edge that is detected at the same clock edge as the in-service rise, or at any later edge while in-service stays high, leaves or sets the pending bit high.
- R9: A register write takes effect at the next clock edge. Word addresses 21 to 31 read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | NUM_SRC | Peripheral request levels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | REG_W | Register write data |
| bus_rdata | output | REG_W | Register read data (combinational) |
| core_insvc | input | NUM_EVT | Per-event in-service indication from the core |
| core_sleep | input | 1 | Core idle/sleep indication |
| evt_pend | output | NUM_EVT | Per-event pending requests to the core |
| wake_out | output | 1 | Registered wake request |

## Verification
The bench targets the case where a new rising edge coincides with the in-service rise. A design that lets the clear win would silently drop that queued event. It also raises a second source on an already-high shared event input; a design that detects edges per source instead of per event would raise a spurious pending bit. It writes to the read-only status words and to unmapped addresses, where a careless decoder would corrupt enable or routing state, and it sweeps routing fields at both ends of a word to catch mistakes in nibble order. Sleep toggling shows whether the wake output is gated and delayed by exactly one register.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;

   // Number of words of 'width' bits needed to hold 'bits' bits
   function automatic int words_for(input int bits, input int width);
      return (bits + width - 1) / width;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/irq_agg_regs.sv
`timescale 1ns/1ps
module irq_agg_regs #(
   parameter int NUM_SRC = 96,
   parameter int REG_W   = 32,
   parameter int EVT_W   = 4,
   parameter int ADDR_W  = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_we,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [REG_W-1:0]         bus_wdata,
   output logic [REG_W-1:0]         bus_rdata,
   input  logic [NUM_SRC-1:0]       src_live,
   output logic [NUM_SRC-1:0]       mask_vec,
   output logic [NUM_SRC-1:0]       wake_vec,
   output logic [NUM_SRC*EVT_W-1:0] map_vec
);
   localparam int SRC_WORDS = irq_agg_pkg::words_for(NUM_SRC, REG_W);
   localparam int MAP_WORDS = irq_agg_pkg::words_for(NUM_SRC * EVT_W, REG_W);
   localparam int STAT_BASE = SRC_WORDS;
   localparam int WAKE_BASE = 2 * SRC_WORDS;
   localparam int MAP_BASE  = 3 * SRC_WORDS;

   logic [REG_W-1:0] mask_q [SRC_WORDS];
   logic [REG_W-1:0] wake_q [SRC_WORDS];
   logic [REG_W-1:0] map_q  [MAP_WORDS];

   logic [SRC_WORDS-1:0] sel_mask, sel_stat, sel_wake;
   logic [MAP_WORDS-1:0] sel_map;

   for (genvar w = 0; w < SRC_WORDS; w++) begin : g_src_word
      assign sel_mask[w] = (bus_addr == ADDR_W'(w));
      assign sel_stat[w] = (bus_addr == ADDR_W'(STAT_BASE + w));
      assign sel_wake[w] = (bus_addr == ADDR_W'(WAKE_BASE + w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q[w] <= '0;
            wake_q[w] <= '0;
         end else if (bus_we) begin
            if (sel_mask[w]) mask_q[w] <= bus_wdata;
            if (sel_wake[w]) wake_q[w] <= bus_wdata;
         end
      end

      assign mask_vec[w*REG_W +: REG_W] = mask_q[w];
      assign wake_vec[w*REG_W +: REG_W] = wake_q[w];
   end

   for (genvar m = 0; m < MAP_WORDS; m++) begin : g_map_word
      assign sel_map[m] = (bus_addr == ADDR_W'(MAP_BASE + m));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    map_q[m] <= '0;
         else if (bus_we && sel_map[m]) map_q[m] <= bus_wdata;
      end

      assign map_vec[m*REG_W +: REG_W] = map_q[m];
   end

   // One-hot word selects; unmapped addresses leave the result at zero
   always_comb begin
      bus_rdata = '0;
      for (int w = 0; w < SRC_WORDS; w++) begin
         if (sel_mask[w]) bus_rdata |= mask_q[w];
         if (sel_stat[w]) bus_rdata |= src_live[w*REG_W +: REG_W];
         if (sel_wake[w]) bus_rdata |= wake_q[w];
      end
      for (int m = 0; m < MAP_WORDS; m++) begin
         if (sel_map[m]) bus_rdata |= map_q[m];
      end
   end

   AST_ONE_WORD_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({sel_mask, sel_stat, sel_wake, sel_map}) <= 1);   // R9

endmodule

// File: rtl/irq_agg_router.sv
`timescale 1ns/1ps
module irq_agg_router #(
   parameter int NUM_SRC = 96,
   parameter int NUM_EVT = 16,
   parameter int EVT_W   = 4
) (
   input  logic [NUM_SRC-1:0]       src_irq,
   input  logic [NUM_SRC-1:0]       mask_vec,
   input  logic [NUM_SRC*EVT_W-1:0] map_vec,
   output logic [NUM_EVT-1:0]       evt_line
);
   logic [NUM_SRC-1:0] live;

   assign live = src_irq & mask_vec;

   // Each enabled request lands on the event input named by its field
   always_comb begin
      evt_line = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (live[s]) evt_line[map_vec[s*EVT_W +: EVT_W]] = 1'b1;
      end
   end

endmodule

// File: rtl/irq_agg_latch.sv
`timescale 1ns/1ps
module irq_agg_latch #(
   parameter int NUM_EVT = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_line,
   input  logic [NUM_EVT-1:0] svc_in,
   output logic [NUM_EVT-1:0] pend
);
   for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
      logic line_d1, line_d2, svc_q, pend_q;
      logic edge_seen, svc_rise;

      assign edge_seen = line_d1 & ~line_d2;
      assign svc_rise  = svc_in[e] & ~svc_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            line_d1 <= 1'b0;
            line_d2 <= 1'b0;
            svc_q   <= 1'b0;
            pend_q  <= 1'b0;
         end else begin
            line_d1 <= evt_line[e];
            line_d2 <= line_d1;
            svc_q   <= svc_in[e];
            // A new edge wins over the service clear, so it is queued
            pend_q  <= edge_seen | (pend_q & ~svc_rise);
         end
      end

      assign pend[e] = pend_q;

      AST_EDGE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(evt_line[e]) && !$past(evt_line[e], 2)) |=> pend[e]);   // R6
      AST_PEND_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend[e]) |-> $past(evt_line[e], 2));                     // R6
      AST_CLEAR_ON_SVC: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(pend[e]) |-> ($past(svc_in[e]) && !$past(svc_in[e], 2))); // R7
   end

endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
module irq_aggregator #(
   parameter  int NUM_SRC      = 96,
   parameter  int REG_W        = 32,
   parameter  int NUM_EVT      = 16,
   localparam int EVT_W        = $clog2(NUM_EVT),
   localparam int SRC_WORDS    = irq_agg_pkg::words_for(NUM_SRC, REG_W),
   localparam int MAP_PER_WORD = REG_W / EVT_W,
   localparam int MAP_WORDS    = irq_agg_pkg::words_for(NUM_SRC, MAP_PER_WORD),
   localparam int TOT_WORDS    = 3 * SRC_WORDS + MAP_WORDS,
   localparam int ADDR_W       = $clog2(TOT_WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_irq,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   input  logic [NUM_EVT-1:0] core_insvc,
   input  logic               core_sleep,
   output logic [NUM_EVT-1:0] evt_pend,
   output logic               wake_out
);
   initial begin
      if (NUM_SRC % REG_W != 0)
         $fatal(1, "source count must fill whole register words");
      if (NUM_EVT < 2 || !irq_agg_pkg::is_pow2(NUM_EVT))
         $fatal(1, "event count must be a power of two, at least 2");
      if (REG_W % EVT_W != 0 || NUM_SRC % MAP_PER_WORD != 0)
         $fatal(1, "routing fields must pack evenly into words");
   end

   logic [NUM_SRC-1:0]       mask_vec, wake_vec;
   logic [NUM_SRC*EVT_W-1:0] map_vec;
   logic [NUM_EVT-1:0]       evt_line;
   logic                     wake_q;

   irq_agg_regs #(
      .NUM_SRC (NUM_SRC),
      .REG_W   (REG_W),
      .EVT_W   (EVT_W),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .src_live  (src_irq),
      .mask_vec  (mask_vec),
      .wake_vec  (wake_vec),
      .map_vec   (map_vec)
   );

   irq_agg_router #(
      .NUM_SRC (NUM_SRC),
      .NUM_EVT (NUM_EVT),
      .EVT_W   (EVT_W)
   ) u_router (
      .src_irq  (src_irq),
      .mask_vec (mask_vec),
      .map_vec  (map_vec),
      .evt_line (evt_line)
   );

   irq_agg_latch #(
      .NUM_EVT (NUM_EVT)
   ) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_line (evt_line),
      .svc_in   (core_insvc),
      .pend     (evt_pend)
   );

   // Wake request: OR across sources, gated by sleep, one register stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_q <= 1'b0;
      else        wake_q <= core_sleep & (|(src_irq & wake_vec));
   end

   assign wake_out = wake_q;

   AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      wake_out |-> $past(core_sleep));                                // R4
   AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_irq & mask_vec) == '0) |-> (evt_line == '0));              // R2

endmodule

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;
   localparam int NS = 96;
   localparam int RW = 32;
   localparam int NE = 16;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src = '0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [RW-1:0] bus_wdata = '0;
   logic [NE-1:0] insvc = '0;
   logic          sleep = 1'b0;
   wire  [RW-1:0] bus_rdata;
   wire  [NE-1:0] evt_pend;
   wire           wake_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   irq_aggregator u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_irq    (src),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .core_insvc (insvc),
      .core_sleep (sleep),
      .evt_pend   (evt_pend),
      .wake_out   (wake_out)
   );

   // ---------------- behavioural reference ----------------
   logic [NS-1:0] m_mask, m_wen;
   int            m_map [NS];
   logic [NE-1:0] m_d1, m_d2, m_ack, m_pend;
   logic          m_wake;

   function automatic logic [RW-1:0] m_read(input int a);
      logic [RW-1:0] r;
      r = '0;
      if (a < 3)       r = m_mask[a*32 +: 32];
      else if (a < 6)  r = src[(a-3)*32 +: 32];
      else if (a < 9)  r = m_wen[(a-6)*32 +: 32];
      else if (a < 21) for (int k = 0; k < 8; k++) r[4*k +: 4] = 4'(m_map[(a-9)*8 + k]);
      return r;
   endfunction

   function automatic string area_tag(input int a);
      if (!rst_n)      return "R1";
      if (a < 3)       return "R2";
      if (a < 6)       return "R3";
      if (a < 9)       return "R4";
      if (a < 21)      return "R5";
      return "R9";
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   always @(posedge clk) begin
      logic [NE-1:0] line;
      logic          any_w;
      int            a;
      if (!rst_n) begin
         m_mask = '0; m_wen = '0;
         for (int s = 0; s < NS; s++) m_map[s] = 0;
         m_d1 = '0; m_d2 = '0; m_ack = '0; m_pend = '0; m_wake = 1'b0;
      end else begin
         line = '0;
         for (int s = 0; s < NS; s++) if (src[s] && m_mask[s]) line[m_map[s]] = 1'b1;
         any_w = |(src & m_wen);
         for (int e = 0; e < NE; e++) begin
            if (m_d1[e] && !m_d2[e])       m_pend[e] = 1'b1;
            else if (insvc[e] && !m_ack[e]) m_pend[e] = 1'b0;
         end
         m_d2 = m_d1; m_d1 = line; m_ack = insvc;
         m_wake = sleep && any_w;
         if (bus_we) begin
            a = int'(bus_addr);
            if (a < 3)                 m_mask[a*32 +: 32] = bus_wdata;
            else if (a >= 6 && a < 9)  m_wen[(a-6)*32 +: 32] = bus_wdata;
            else if (a >= 9 && a < 21) for (int k = 0; k < 8; k++) m_map[(a-9)*8 + k] = int'(bus_wdata[4*k +: 4]);
         end
      end
      #1;
      a = int'(bus_addr);
      chk(evt_pend == m_pend, rst_n ? "R6/R7/R8" : "R1", RW'(evt_pend), RW'(m_pend));
      chk(wake_out == m_wake, rst_n ? "R4" : "R1", RW'(wake_out), RW'(m_wake));
      chk(bus_rdata == m_read(a), area_tag(a), bus_rdata, m_read(a));
   end

   // ---------------- stimulus ----------------
   task automatic wr(input int a, input logic [RW-1:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(evt_pend == '0 && wake_out == 1'b0, "R1", RW'(evt_pend), '0);
      rst_n = 1'b1;

      // R1 / R9: sweep every address after reset
      for (int a = 0; a < 32; a++) begin @(negedge clk); bus_addr = AW'(a); end

      // R3: live status, and writes to it ignored
      @(negedge clk) src = {32'hA5A5_0F0F, 32'h1234_5678, 32'hDEAD_BEEF};
      for (int a = 3; a < 6; a++) begin @(negedge clk); bus_addr = AW'(a); end
      wr(4, 32'hFFFF_FFFF);
      bus_addr = 5'd4;
      @(posedge clk); #1;
      chk(bus_rdata == 32'h1234_5678, "R3", bus_rdata, 32'h1234_5678);
      bus_addr = 5'd1;
      @(posedge clk); #1;
      chk(bus_rdata == '0, "R3", bus_rdata, '0);
      @(negedge clk) src = '0;

      // R9: writes to unmapped addresses ignored
      wr(25, 32'hFFFF_FFFF);
      wr(31, 32'h1234_5678);
      bus_addr = 5'd25;
      @(posedge clk); #1;
      chk(bus_rdata == '0, "R9", bus_rdata, '0);

      // R2: toggling a disabled source does nothing
      for (int i = 0; i < 4; i++) begin @(negedge clk); src[40] = ~src[40]; end
      @(negedge clk); src[40] = 1'b0;
      repeat (3) @(negedge clk);
      chk(evt_pend == '0, "R2", RW'(evt_pend), '0);

      // R5 / R6: source 40 -> event 5 (word 14, low nibble); enable word 1 bit 8
      wr(14, 32'h0000_0005);
      wr(1, 32'h0000_0100);
      @(negedge clk); src[40] = 1'b1;
      @(negedge clk);
      chk(evt_pend[5] == 1'b0, "R6", RW'(evt_pend), '0);
      @(negedge clk);
      chk(evt_pend == 16'h0020, "R6", RW'(evt_pend), 32'h20);

      // R7: in-service rise clears
      insvc[5] = 1'b1;
      @(negedge clk);
      chk(evt_pend[5] == 1'b0, "R7", RW'(evt_pend), '0);
      repeat (3) @(negedge clk);
      chk(evt_pend[5] == 1'b0, "R6", RW'(evt_pend), '0);   // held level, no retrigger

      // R8: new edge while in-service still high
      src[40] = 1'b0;
      @(negedge clk) src[40] = 1'b1;
      repeat (2) @(negedge clk);
      chk(evt_pend[5] == 1'b1, "R8", RW'(evt_pend), 32'h20);

      // R8: edge detected at the same clock as the in-service rise
      insvc[5] = 1'b0; src[40] = 1'b0;
      @(negedge clk); src[40] = 1'b1;
      @(negedge clk); insvc[5] = 1'b1;
      @(negedge clk);
      chk(evt_pend[5] == 1'b1, "R8", RW'(evt_pend), 32'h20);
      insvc[5] = 1'b0;
      @(negedge clk); insvc[5] = 1'b1;
      @(negedge clk);
      chk(evt_pend[5] == 1'b0, "R7", RW'(evt_pend), '0);
      insvc[5] = 1'b0;

      // R5: sharing — source 0 also on event 5, rises while line already high
      wr(9, 32'h0000_0005);
      wr(0, 32'h0000_0001);
      @(negedge clk); src[0] = 1'b1;
      repeat (3) @(negedge clk);
      chk(evt_pend[5] == 1'b0, "R5", RW'(evt_pend), '0);
      src[40] = 1'b0;
      repeat (3) @(negedge clk);
      chk(evt_pend[5] == 1'b0, "R5", RW'(evt_pend), '0);
      src[0] = 1'b0;

      // R5: source 95 -> event 15 (word 20, top nibble); enable word 2 bit 31
      wr(20, 32'hF000_0000);
      wr(2, 32'h8000_0000);
      @(negedge clk); src[95] = 1'b1;
      repeat (2) @(negedge clk);
      chk(evt_pend[15] == 1'b1, "R5", RW'(evt_pend), 32'h8000);

      // R4: wake path
      wr(8, 32'h8000_0000);
      sleep = 1'b0;
      repeat (2) @(negedge clk);
      chk(wake_out == 1'b0, "R4", RW'(wake_out), '0);
      sleep = 1'b1;
      @(negedge clk);
      chk(wake_out == 1'b1, "R4", RW'(wake_out), 32'h1);
      sleep = 1'b0;
      @(negedge clk);
      chk(wake_out == 1'b0, "R4", RW'(wake_out), '0);
      src = '0;

      // Mixed random traffic compared against the model every cycle
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         src[$urandom_range(NS-1, 0)] ^= 1'b1;
         if ($urandom_range(3, 0) == 0) src[$urandom_range(NS-1, 0)] ^= 1'b1;
         insvc = NE'($urandom);
         sleep = ($urandom_range(1, 0) == 1);
         if ($urandom_range(15, 0) == 0) begin
            bus_we = 1'b1;
            bus_addr = AW'($urandom_range(31, 0));
            bus_wdata = $urandom;
         end else begin
            bus_we = 1'b0;
            bus_addr = AW'($urandom_range(31, 0));
         end
      end
      @(negedge clk) bus_we = 1'b0;
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1..all watchdog expired at %0t: actual hung expected done", $time);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule